// File: doc/BRIEF.md
# Transmit FIFO Start and Retain Control

This block sits beside the transmit byte FIFO of an Ethernet MAC. The transmit DMA loads a frame one byte at a time, and the last byte carries an end-of-frame flag. The block decides two things. It raises `tx_start_ok` once enough of the frame is stored for the MAC to begin preamble. It raises `dma_req_ok` while the FIFO can still take the number of write cycles that the watermark setting selects. The FIFO holds one frame at a time. After the end-of-frame byte is stored, further writes wait until `frame_done`.

The first bytes of a frame stay protected in storage until 64 of them have gone out on the wire, or until the frame is released. If a collision falls inside that window, `collision_retry` moves the read side back to the first byte, so the MAC can resend without the host refilling the FIFO. Two small configuration fields set the start threshold and the watermark. They accept writes only while the stop/suspend input `cfg_open` is high.

Top module: `txfifo_start_ctl`

## Requirements
- R1: `tx_start_ok` is high when the number of bytes of the current frame written so far is at least the start threshold. The threshold is set by `start_sel_q`: 00=4, 01=16, 10=64, 11=112 bytes. The output reflects a write in the cycle after the write.
- R2: Once the byte flagged `wr_last` has been written, `tx_start_ok` is high whatever the start threshold.
- R3: After reset, `start_sel_q`=10, `wmark_sel_q`=00, `tx_start_ok`=0, `dma_req_ok`=1, `space_avail`=DEPTH and `rd_valid`=0.
- R4: A write with `cfg_we` updates `start_sel_q` and `wmark_sel_q` only while `cfg_open` is high. When `cfg_open` is low, the write leaves both fields unchanged.
- R5: `dma_req_ok` is high exactly when the end of the frame has not been written and `space_avail` is at least the watermark. The watermark is set by `wmark_sel_q`: 00=8, 01=16, 10=32, 11=8 write cycles.
- R6: Bytes read from the FIFO still count as occupied until 64 bytes of the frame have been read. After that, each read frees its location at once. A frame shorter than 64 bytes keeps all of its locations until `frame_done`.
- R7: `collision_retry` rewinds the read side to the first byte of the frame when it arrives while fewer than 64 bytes have been read. In that case the next `rd_data` is the first byte and `space_avail` is unchanged. If 64 or more bytes have been read, `collision_retry` is ignored.
- R8: `frame_done` releases the frame. In the next cycle `space_avail`=DEPTH, `tx_start_ok`=0 and `rd_valid`=0. A write or read in the same cycle as `frame_done` is dropped.
- R9: A write is dropped when `space_avail` is 0 or when the end-of-frame byte is already stored. `space_avail` never exceeds DEPTH.
- R10: Bytes are read in the order they were written. `rd_valid` is high while unread bytes exist. `rd_last` is high when `rd_data` is the end-of-frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_open | input | 1 | Stop/suspend state; enables configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_start_sel | input | 2 | Start threshold code to write |
| cfg_wmark_sel | input | 2 | Watermark code to write |
| start_sel_q | output | 2 | Current start threshold code |
| wmark_sel_q | output | 2 | Current watermark code |
| wr_en | input | 1 | DMA byte write |
| wr_data | input | DW | Byte written |
| wr_last | input | 1 | Byte is the last one of the frame |
| rd_en | input | 1 | MAC byte read |
| rd_data | output | DW | Byte at the read position |
| rd_valid | output | 1 | Unread byte available |
| rd_last | output | 1 | `rd_data` is the end-of-frame byte |
| collision_retry | input | 1 | Collision seen; request resend from frame start |
| frame_done | input | 1 | Frame finished; release all its storage |
| space_avail | output | $clog2(DEPTH)+1 | Free byte locations |
| tx_start_ok | output | 1 | MAC may start preamble |
| dma_req_ok | output | 1 | DMA may request write cycles |

## Verification
The bench sweeps all four start codes over frame lengths that sit just below, at and just above each threshold, including frames that end before reaching it. A design that compared with the wrong bound, or ignored the end flag, would raise the start permission a byte early or late, or never raise it for a short frame. It also fills the FIFO byte by byte under every watermark code, including the reserved one, and tracks free space through the 63rd and 64th reads of a frame. A design that freed storage too early would report space in the retained window. A design that rewound after the window would replay bytes that the retry rule says are gone for good.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

  typedef logic [1:0] sel_t;

  localparam sel_t START_SEL_RST = 2'b10;
  localparam sel_t WMARK_SEL_RST = 2'b00;

  // Bytes of the current frame needed before preamble may begin.
  function automatic int unsigned start_bytes(sel_t s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 112;
    endcase
  endfunction

  // Write cycles that must fit before DMA may request; code 11 acts as 00.
  function automatic int unsigned wmark_cycles(sel_t s);
    case (s)
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/txfs_cfg.sv
module txfs_cfg
  import txfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_open,
  input  logic cfg_we,
  input  sel_t start_in,
  input  sel_t wmark_in,
  output sel_t start_q,
  output sel_t wmark_q,
  output logic cfg_take
);

  assign cfg_take = cfg_we && cfg_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= START_SEL_RST;
      wmark_q <= WMARK_SEL_RST;
    end else if (cfg_take) begin
      start_q <= start_in;
      wmark_q <= wmark_in;
    end
  end

endmodule

// File: rtl/txfs_store.sv
module txfs_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/txfs_ptrs.sv
module txfs_ptrs #(
  parameter int DEPTH  = 128,
  parameter int RETAIN = 64,
  parameter int CW     = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_last,
  input  logic          rd_en,
  input  logic          collision_retry,
  input  logic          frame_done,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [CW-1:0] wr_cnt,
  output logic [CW-1:0] sent_cnt,
  output logic          eof_seen,
  output logic [PW-1:0] space,
  output logic          retry_win,
  output logic          retry_take,
  output logic [PW-1:0] rd_ptr_o,
  output logic [PW-1:0] start_ptr_o
);

  logic [PW-1:0] wr_ptr, rd_ptr, ret_ptr, start_ptr;
  logic [PW-1:0] used, rd_ptr_inc;
  logic [CW-1:0] wr_cnt_inc, sent_inc;

  assign used       = wr_ptr - ret_ptr;
  assign space      = PW'(DEPTH) - used;
  assign rd_valid   = rd_ptr != wr_ptr;
  assign rd_ptr_inc = rd_ptr + PW'(1);
  assign rd_last    = eof_seen && (rd_ptr_inc == wr_ptr);

  assign retry_win  = sent_cnt < CW'(RETAIN);
  assign retry_take = collision_retry && retry_win && !frame_done;
  assign rd_fire    = rd_en && rd_valid && !frame_done && !retry_take;
  assign wr_fire    = wr_en && (space != '0) && !eof_seen && !frame_done;

  assign wr_cnt_inc = (wr_cnt == '1) ? wr_cnt : wr_cnt + CW'(1);
  assign sent_inc   = (sent_cnt == '1) ? sent_cnt : sent_cnt + CW'(1);

  assign wr_addr     = wr_ptr[AW-1:0];
  assign rd_addr     = rd_ptr[AW-1:0];
  assign rd_ptr_o    = rd_ptr;
  assign start_ptr_o = start_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      ret_ptr   <= '0;
      start_ptr <= '0;
      wr_cnt    <= '0;
      sent_cnt  <= '0;
      eof_seen  <= 1'b0;
    end else if (frame_done) begin
      rd_ptr    <= wr_ptr;
      ret_ptr   <= wr_ptr;
      start_ptr <= wr_ptr;
      wr_cnt    <= '0;
      sent_cnt  <= '0;
      eof_seen  <= 1'b0;
    end else begin
      if (wr_fire) begin
        wr_ptr <= wr_ptr + PW'(1);
        wr_cnt <= wr_cnt_inc;
        if (wr_last) eof_seen <= 1'b1;
      end
      if (retry_take) begin
        rd_ptr   <= start_ptr;
        ret_ptr  <= start_ptr;
        sent_cnt <= '0;
      end else if (rd_fire) begin
        rd_ptr   <= rd_ptr_inc;
        sent_cnt <= sent_inc;
        if (sent_inc >= CW'(RETAIN)) ret_ptr <= rd_ptr_inc;
      end
    end
  end

endmodule

// File: rtl/txfifo_start_ctl.sv
module txfifo_start_ctl
  import txfs_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DW     = 8,
  parameter int RETAIN = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int CW    = $clog2(DEPTH > RETAIN ? DEPTH : RETAIN) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_open,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_start_sel,
  input  logic [1:0]    cfg_wmark_sel,
  output logic [1:0]    start_sel_q,
  output logic [1:0]    wmark_sel_q,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_last,
  input  logic          collision_retry,
  input  logic          frame_done,
  output logic [PW-1:0] space_avail,
  output logic          tx_start_ok,
  output logic          dma_req_ok
);

  // Internal events brought out for the checker.
  logic          cfg_take;
  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] wr_cnt, sent_cnt;
  logic          eof_seen;
  logic          retry_win, retry_take;
  logic [PW-1:0] rd_ptr_w, start_ptr_w;
  logic          thresh_hit, room_hit;

  txfs_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_open (cfg_open),
    .cfg_we   (cfg_we),
    .start_in (cfg_start_sel),
    .wmark_in (cfg_wmark_sel),
    .start_q  (start_sel_q),
    .wmark_q  (wmark_sel_q),
    .cfg_take (cfg_take)
  );

  txfs_ptrs #(.DEPTH(DEPTH), .RETAIN(RETAIN), .CW(CW)) u_ptrs (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_last         (wr_last),
    .rd_en           (rd_en),
    .collision_retry (collision_retry),
    .frame_done      (frame_done),
    .wr_fire         (wr_fire),
    .rd_fire         (rd_fire),
    .wr_addr         (wr_addr),
    .rd_addr         (rd_addr),
    .rd_valid        (rd_valid),
    .rd_last         (rd_last),
    .wr_cnt          (wr_cnt),
    .sent_cnt        (sent_cnt),
    .eof_seen        (eof_seen),
    .space           (space_avail),
    .retry_win       (retry_win),
    .retry_take      (retry_take),
    .rd_ptr_o        (rd_ptr_w),
    .start_ptr_o     (start_ptr_w)
  );

  txfs_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign thresh_hit  = wr_cnt >= CW'(start_bytes(start_sel_q));
  assign room_hit    = space_avail >= PW'(wmark_cycles(wmark_sel_q));
  assign tx_start_ok = thresh_hit || eof_seen;
  assign dma_req_ok  = room_hit && !eof_seen;

endmodule

// File: rtl/txfs_checker.sv
module txfs_checker #(
  parameter int DEPTH  = 128,
  parameter int RETAIN = 64,
  parameter int PW     = 8,
  parameter int CW     = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_open,
  input logic [1:0]    start_sel_q,
  input logic [1:0]    wmark_sel_q,
  input logic          frame_done,
  input logic          rd_fire,
  input logic          retry_take,
  input logic          eof_seen,
  input logic [CW-1:0] sent_cnt,
  input logic [PW-1:0] rd_ptr_w,
  input logic [PW-1:0] start_ptr_w,
  input logic [PW-1:0] space_avail,
  input logic          tx_start_ok,
  input logic          dma_req_ok
);

  AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(start_sel_q) && $stable(wmark_sel_q))); // R4

  AST_EOF_START: assert property (@(posedge clk) disable iff (!rst_n)
    eof_seen |-> tx_start_ok); // R2

  AST_DMA_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_ok |-> (space_avail >= PW'(8) && !eof_seen)); // R5

  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sent_cnt < CW'(RETAIN - 1) && !frame_done)
      |=> space_avail <= $past(space_avail)); // R6

  AST_RETRY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    retry_take |=> rd_ptr_w == $past(start_ptr_w)); // R7

  AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (space_avail == PW'(DEPTH) && !tx_start_ok)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    space_avail <= PW'(DEPTH)); // R9

endmodule

bind txfifo_start_ctl txfs_checker #(
  .DEPTH(DEPTH), .RETAIN(RETAIN), .PW(PW), .CW(CW)
) u_txfs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_open    (cfg_open),
  .start_sel_q (start_sel_q),
  .wmark_sel_q (wmark_sel_q),
  .frame_done  (frame_done),
  .rd_fire     (rd_fire),
  .retry_take  (retry_take),
  .eof_seen    (eof_seen),
  .sent_cnt    (sent_cnt),
  .rd_ptr_w    (rd_ptr_w),
  .start_ptr_w (start_ptr_w),
  .space_avail (space_avail),
  .tx_start_ok (tx_start_ok),
  .dma_req_ok  (dma_req_ok)
);

// File: tb/test_txfifo_start_ctl.sv
module test_txfifo_start_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int DW    = 8;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_open = 1'b0, cfg_we = 1'b0;
  logic [1:0]    cfg_start_sel = '0, cfg_wmark_sel = '0;
  logic [1:0]    start_sel_q, wmark_sel_q;
  logic          wr_en = 1'b0, wr_last = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rd_last;
  logic          collision_retry = 1'b0, frame_done = 1'b0;
  logic [PW-1:0] space_avail;
  logic          tx_start_ok, dma_req_ok;

  int n_checks = 0;
  int n_fails  = 0;
  bit ended    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txfifo_start_ctl #(.DEPTH(DEPTH), .DW(DW), .RETAIN(64)) i_txfifo_start_ctl (
    .clk, .rst_n, .cfg_open, .cfg_we, .cfg_start_sel, .cfg_wmark_sel,
    .start_sel_q, .wmark_sel_q, .wr_en, .wr_data, .wr_last, .rd_en,
    .rd_data, .rd_valid, .rd_last, .collision_retry, .frame_done,
    .space_avail, .tx_start_ok, .dma_req_ok
  );

  function automatic int thr_of(int s);
    return (s == 0) ? 4 : (s == 1) ? 16 : (s == 2) ? 64 : 112;
  endfunction

  function automatic int wm_of(int s);
    return (s == 1) ? 16 : (s == 2) ? 32 : 8;
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 7 + i * 3 + 1) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic cfg_write(bit open, int s, int w);
    cfg_open = open; cfg_we = 1'b1;
    cfg_start_sel = 2'(s); cfg_wmark_sel = 2'(w);
    @(negedge clk);
    cfg_we = 1'b0; cfg_open = 1'b0;
  endtask

  task automatic wr_byte(logic [7:0] d, bit last);
    wr_en = 1'b1; wr_data = d; wr_last = last;
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  task automatic rd_byte();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic pulse_coll();
    collision_retry = 1'b1;
    @(negedge clk);
    collision_retry = 1'b0;
  endtask

  task automatic load_frame(int seed, int len);
    for (int i = 0; i < len; i++) wr_byte(pat(seed, i), i == len - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int lens[7] = '{3, 4, 16, 63, 64, 112, 113};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    check("R3 start_sel", int'(start_sel_q), 2);
    check("R3 wmark_sel", int'(wmark_sel_q), 0);
    check("R3 tx_start_ok", int'(tx_start_ok), 0);
    check("R3 dma_req_ok", int'(dma_req_ok), 1);
    check("R3 space", int'(space_avail), DEPTH);
    check("R3 rd_valid", int'(rd_valid), 0);

    // R4 locked writes are ignored, open writes land
    cfg_write(1'b0, 0, 3);
    check("R4 locked start", int'(start_sel_q), 2);
    check("R4 locked wmark", int'(wmark_sel_q), 0);
    cfg_write(1'b1, 1, 2);
    check("R4 open start", int'(start_sel_q), 1);
    check("R4 open wmark", int'(wmark_sel_q), 2);

    // R1/R2 start threshold sweep
    for (int s = 0; s < 4; s++) begin
      cfg_write(1'b1, s, 0);
      for (int k = 0; k < 7; k++) begin
        for (int i = 0; i < lens[k]; i++) begin
          wr_byte(pat(s + k, i), i == lens[k] - 1);
          if (i == lens[k] - 1)
            check("R2 eof start", int'(tx_start_ok), 1);
          else
            check("R1 threshold", int'(tx_start_ok), int'((i + 1) >= thr_of(s)));
        end
        pulse_done();
        check("R8 done space", int'(space_avail), DEPTH);
        check("R8 done start", int'(tx_start_ok), 0);
        check("R8 done rd_valid", int'(rd_valid), 0);
      end
    end

    // R5 watermark sweep, R9 full FIFO
    for (int w = 0; w < 4; w++) begin
      cfg_write(1'b1, 2, w);
      check("R5 empty", int'(dma_req_ok), 1);
      for (int i = 0; i < DEPTH; i++) begin
        wr_byte(pat(w, i), 1'b0);
        check("R5 watermark", int'(dma_req_ok), int'((DEPTH - i - 1) >= wm_of(w)));
      end
      check("R9 full space", int'(space_avail), 0);
      wr_byte(8'hAA, 1'b1);
      check("R9 full drop", int'(space_avail), 0);
      check("R9 full drop eof", int'(dma_req_ok), 0);
      pulse_done();
    end

    // R6/R10 retain window over a 100-byte frame
    cfg_write(1'b1, 2, 0);
    load_frame(5, 100);
    check("R6 loaded space", int'(space_avail), 28);
    check("R5 eof blocks dma", int'(dma_req_ok), 0);
    for (int i = 0; i < 100; i++) begin
      check("R10 rd_valid", int'(rd_valid), 1);
      check("R10 rd_data", int'(rd_data), int'(pat(5, i)));
      check("R10 rd_last", int'(rd_last), int'(i == 99));
      rd_byte();
      check("R6 space", int'(space_avail), (i + 1 >= 64) ? DEPTH - (99 - i) : 28);
    end
    check("R10 drained", int'(rd_valid), 0);
    wr_byte(8'h11, 1'b0);
    check("R9 after eof", int'(space_avail), DEPTH);
    pulse_done();

    // R7 retry inside window, then ignored past it
    load_frame(9, 100);
    for (int i = 0; i < 30; i++) rd_byte();
    check("R7 pre data", int'(rd_data), int'(pat(9, 30)));
    pulse_coll();
    check("R7 rewind data", int'(rd_data), int'(pat(9, 0)));
    check("R7 rewind space", int'(space_avail), 28);
    for (int i = 0; i < 64; i++) begin
      check("R7 replay data", int'(rd_data), int'(pat(9, i)));
      rd_byte();
    end
    pulse_coll();
    check("R7 late ignored data", int'(rd_data), int'(pat(9, 64)));
    check("R7 late ignored space", int'(space_avail), DEPTH - 36);
    pulse_done();

    // R6/R7 short frame keeps every byte until release
    load_frame(13, 20);
    for (int i = 0; i < 20; i++) rd_byte();
    check("R6 short retained", int'(space_avail), DEPTH - 20);
    check("R10 short drained", int'(rd_valid), 0);
    pulse_coll();
    check("R7 short rewind", int'(rd_data), int'(pat(13, 0)));
    check("R7 short valid", int'(rd_valid), 1);
    pulse_done();
    check("R8 short free", int'(space_avail), DEPTH);

    summary();
  end

endmodule